// File: doc/BRIEF.md
# ADC conversion trigger controller

This block is the digital sequencer that sits next to a successive-approximation converter. It divides the system clock into a converter clock enable, decides when a conversion begins, tracks the conversion while it runs, and raises a completion flag when it ends. The analog part is not modelled. A conversion is a fixed count of converter clock periods. Result data are handled elsewhere.

Software drives the block through register-style fields: an enable, a write-one start strobe, an auto-trigger enable, a trigger-source code, a divider code and a write-one flag clear. Hardware supplies a vector of trigger lines and a flag that marks the selected channel as amplified. When trigger code 0 is selected, the completion event acts as its own trigger. Conversions then run back to back after one software start, even if software never clears the flag. This self-restart is suppressed when the channel is amplified.

Top module: `adc_trig_ctrl`

## Requirements
- R1: `adc_clk_en` is a one-cycle pulse every N system clocks, never on two cycles in a row. N for `cfg_div_sel` codes 0..7 is 2, 2, 4, 8, 16, 32, 64, 128.
- R2: While `cfg_enable` is 0 the divider is held at its start value and `adc_clk_en` stays 0. A running conversion is dropped, so `conv_busy` is 0 from the next cycle. A `sw_start` pulse has no effect.
- R3: When the block is enabled and idle, a one-cycle `sw_start` pulse makes `conv_busy` read 1 from the next cycle. This holds whatever the value of `cfg_auto_en`.
- R4: A conversion ends on the 13th `adc_clk_en` pulse seen while `conv_busy` is 1. In the next cycle `conv_busy` reads 0 and `conv_done` reads 1 together.
- R5: Trigger code k in 1..7 selects `trig_in[k-1]`. With `cfg_auto_en` = 1 and the block idle, a rising edge on that line (0 in one cycle, 1 in the next) makes `conv_busy` 1 one cycle after the line rises. Edges on lines that are not selected, and all edges while `cfg_auto_en` = 0, start nothing.
- R6: A trigger edge that arrives while `conv_busy` is 1 is dropped and is not remembered for later.
- R7: Trigger code 0 with `cfg_auto_en` = 1 and `chan_amplified` = 0 gives free-running operation. After each completion `conv_busy` is 0 for exactly one cycle and then 1 again, whether or not `conv_done` has been cleared.
- R8: In free-running operation the first conversion begins only on a `sw_start` pulse.
- R9: With `chan_amplified` = 1, a completion never restarts a conversion by itself.
- R10: A one-cycle `flag_clr` pulse clears `conv_done` in the next cycle.
- R11: After reset `conv_busy`, `conv_done` and `adc_clk_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Converter enable; divider held at start value while 0 |
| cfg_auto_en | input | 1 | Allows hardware-triggered starts |
| cfg_trig_sel | input | 3 | Trigger code: 0 = completion event, k = trig_in[k-1] |
| cfg_div_sel | input | 3 | Divider code for the converter clock |
| sw_start | input | 1 | Write-one strobe that starts a conversion |
| flag_clr | input | 1 | Write-one strobe that clears the completion flag |
| trig_in | input | 7 | Synchronous hardware trigger lines |
| chan_amplified | input | 1 | Selected channel is amplified; blocks self-restart |
| adc_clk_en | output | 1 | One-cycle converter clock enable pulse |
| conv_busy | output | 1 | Conversion in progress (start bit read value) |
| conv_done | output | 1 | Completion flag |

## Verification
A start strobe or a trigger edge shows up as `conv_busy` high in the first cycle after it is sampled. The flag clear shows up on `conv_done` in the cycle after it. Completion shows up as `conv_busy` low and `conv_done` high in the cycle after the 13th counted divider pulse. A free-running restart shows up one cycle after that. The bench drives inputs just after a rising edge and samples on the falling edge of the cycle where each result is due. A scoreboard monitor counts divider pulses while busy and pops one queued expectation at each busy-to-idle transition. Divider periods are measured as the second gap between pulses after a code change, so a partially elapsed count does not affect the result.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int PRE_W      = 7;
    localparam int SEL_W      = 3;
    localparam int CONV_TICKS = 13;
    localparam int NUM_EXT    = (1 << SEL_W) - 1;
    localparam int CNT_W      = $clog2(CONV_TICKS);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PRE_W-1:0] pre_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sw;
        logic ext;
        logic self_restart;
    } start_cause_t;

    // Low-bit mask whose all-ones pattern marks one divider period.
    function automatic pre_t div_mask(input sel_t code);
        int sh;
        sh = (code == '0) ? 1 : int'(code);
        return pre_t'((32'd1 << sh) - 32'd1);
    endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  sel_t div_sel,
    output logic tick
);

    pre_t count_q;
    pre_t mask;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + pre_t'(1);
        end
    end

    always_comb begin
        mask = div_mask(div_sel);
        tick = run && ((count_q | ~mask) == '1);
    end

endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
#(
    parameter int N_SRC = NUM_EXT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] trig_in,
    input  sel_t             sel,
    output logic             ext_edge,
    output logic             self_sel
);

    logic [N_SRC-1:0] trig_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
        end else begin
            trig_q <= trig_in;
        end
    end

    assign rise = trig_in & ~trig_q;

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign hit[k] = rise[k] && (sel == SEL_W'(k + 1));
    end

    assign ext_edge = |hit;
    assign self_sel = (sel == '0);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic sw_start,
    input  logic ext_go,
    input  logic self_ok,
    input  logic flag_clr,
    output logic busy,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] ticks_q;
    logic             end_q;
    logic             flag_q;
    start_cause_t     cause;
    logic             start_req;
    logic             finish;

    always_comb begin
        cause.sw           = sw_start;
        cause.ext          = ext_go;
        cause.self_restart = self_ok && end_q;
        start_req = enable && (state_q == SEQ_IDLE) && (cause != '0);
        finish    = enable && (state_q == SEQ_CONV) && tick && (ticks_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ticks_q <= '0;
            end_q   <= 1'b0;
        end else begin
            end_q <= finish;
            if (!enable) begin
                state_q <= SEQ_IDLE;
                ticks_q <= '0;
            end else if (state_q == SEQ_IDLE) begin
                ticks_q <= '0;
                if (start_req) begin
                    state_q <= SEQ_CONV;
                end
            end else if (tick) begin
                if (finish) begin
                    state_q <= SEQ_IDLE;
                    ticks_q <= '0;
                end else begin
                    ticks_q <= ticks_q + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (finish) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign busy = (state_q == SEQ_CONV);
    assign done = flag_q;

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_enable,
    input  logic               cfg_auto_en,
    input  logic [SEL_W-1:0]   cfg_trig_sel,
    input  logic [SEL_W-1:0]   cfg_div_sel,
    input  logic               sw_start,
    input  logic               flag_clr,
    input  logic [NUM_EXT-1:0] trig_in,
    input  logic               chan_amplified,
    output logic               adc_clk_en,
    output logic               conv_busy,
    output logic               conv_done
);

    logic ext_edge;
    logic self_sel;
    logic ext_go;
    logic self_ok;

    adc_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg_enable),
        .div_sel (cfg_div_sel),
        .tick    (adc_clk_en)
    );

    adc_trig_select #(.N_SRC(NUM_EXT)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (trig_in),
        .sel      (cfg_trig_sel),
        .ext_edge (ext_edge),
        .self_sel (self_sel)
    );

    assign ext_go  = cfg_auto_en && ext_edge;
    assign self_ok = cfg_auto_en && self_sel && !chan_amplified;

    adc_conv_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_enable),
        .tick     (adc_clk_en),
        .sw_start (sw_start),
        .ext_go   (ext_go),
        .self_ok  (self_ok),
        .flag_clr (flag_clr),
        .busy     (conv_busy),
        .done     (conv_done)
    );

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
    import adc_trig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_auto_en,
    input logic [SEL_W-1:0] cfg_trig_sel,
    input logic             sw_start,
    input logic             flag_clr,
    input logic             chan_amplified,
    input logic             adc_clk_en,
    input logic             conv_busy,
    input logic             conv_done
);

    a_r1_no_back_to_back_tick: assert property (@(posedge clk) disable iff (rst)
        adc_clk_en |=> !adc_clk_en);

    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> !adc_clk_en);

    a_r2_abort_on_disable: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !conv_busy);

    a_r3_busy_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_busy) |-> $past(cfg_enable));

    a_r4_flag_with_busy_drop: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_done) |-> $fell(conv_busy));

    a_r4_completion_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_busy) && $past(cfg_enable)) |-> conv_done);

    a_r7_free_run_restart: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_busy) && $past(cfg_enable) && cfg_enable && cfg_auto_en
         && (cfg_trig_sel == '0) && !chan_amplified) |=> conv_busy);

    a_r9_amplified_no_restart: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_busy) && chan_amplified && !sw_start && (cfg_trig_sel == '0))
        |=> !conv_busy);

    a_r10_flag_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_done) |-> $past(flag_clr));

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_enable     (cfg_enable),
    .cfg_auto_en    (cfg_auto_en),
    .cfg_trig_sel   (cfg_trig_sel),
    .sw_start       (sw_start),
    .flag_clr       (flag_clr),
    .chan_amplified (chan_amplified),
    .adc_clk_en     (adc_clk_en),
    .conv_busy      (conv_busy),
    .conv_done      (conv_done)
);

// File: tb/sim_adc_trig_ctrl.sv
`timescale 1ns/1ps
module sim_adc_trig_ctrl;

    localparam int CYC   = 20;
    localparam int TICKS = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0;
    logic       cfg_auto_en = 1'b0;
    logic [2:0] cfg_trig_sel = 3'd0;
    logic [2:0] cfg_div_sel = 3'd0;
    logic       sw_start = 1'b0;
    logic       flag_clr = 1'b0;
    logic [6:0] trig_in = 7'd0;
    logic       chan_amplified = 1'b0;
    logic       adc_clk_en;
    logic       conv_busy;
    logic       conv_done;

    int n_cmp = 0;
    int n_bad = 0;
    string exp_q[$];

    adc_trig_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_auto_en(cfg_auto_en),
        .cfg_trig_sel(cfg_trig_sel), .cfg_div_sel(cfg_div_sel), .sw_start(sw_start),
        .flag_clr(flag_clr), .trig_in(trig_in), .chan_amplified(chan_amplified),
        .adc_clk_en(adc_clk_en), .conv_busy(conv_busy), .conv_done(conv_done)
    );

    always #(CYC/2) clk = ~clk;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: counts divider pulses while busy, pops one expectation per completion.
    int  tick_seen = 0;
    bit  prev_busy = 1'b0;
    bit  prev_en   = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            tick_seen = 0;
            prev_busy = 1'b0;
            prev_en   = 1'b0;
        end else begin
            if (prev_busy && !conv_busy && prev_en) begin
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R4: unexpected completion actual 1 expected 0");
                end else begin
                    string t;
                    t = exp_q.pop_front();
                    chk_eq({t, " R4 tick count"}, tick_seen, TICKS);
                    chk_eq({t, " R4 flag with idle"}, int'(conv_done), 1);
                end
            end
            if (!conv_busy) tick_seen = 0;
            else if (adc_clk_en) tick_seen++;
            prev_busy = conv_busy;
            prev_en   = cfg_enable;
        end
    end

    // Move to 2 ns after the n-th following rising edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        sw_start = 1'b1;
        step(1);
        sw_start = 1'b0;
    endtask

    task automatic pulse_clear();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(posedge clk);
        #2;
    endtask

    task automatic busy_stays_low(input string tag, input int n);
        int hits;
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_busy) hits++;
        end
        chk_eq(tag, hits, 0);
        step(1);
    endtask

    task automatic measure_period(input logic [2:0] code, input int exp);
        int gap;
        cfg_div_sel = code;
        step(1);
        for (int pass = 0; pass < 2; pass++) begin
            do @(negedge clk); while (!adc_clk_en);
        end
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!adc_clk_en);
        chk_eq($sformatf("R1 period for code %0d", code), gap, exp);
        step(1);
    endtask

    initial begin
        #(CYC * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R11 busy after reset", int'(conv_busy), 0);
        chk_eq("R11 flag after reset", int'(conv_done), 0);
        chk_eq("R11 clk enable after reset", int'(adc_clk_en), 0);
        step(1);

        // R2: disabled block
        begin
            int pulses;
            pulses = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (adc_clk_en) pulses++;
            end
            chk_eq("R2 no pulses while disabled", pulses, 0);
        end
        step(1);
        pulse_start();
        @(negedge clk);
        chk_eq("R2 start ignored while disabled", int'(conv_busy), 0);
        step(1);

        // R1: divider periods
        cfg_enable = 1'b1;
        measure_period(3'd0, 2);
        measure_period(3'd1, 2);
        measure_period(3'd3, 8);
        measure_period(3'd7, 128);
        cfg_div_sel = 3'd0;
        step(1);

        // R3/R4: software start, auto triggering off
        exp_q.push_back("R3");
        pulse_start();
        @(negedge clk);
        chk_eq("R3 busy after start", int'(conv_busy), 1);
        wait_empty();
        @(negedge clk);
        chk_eq("R4 flag held after completion", int'(conv_done), 1);
        step(1);

        // R10: flag clear
        pulse_clear();
        @(negedge clk);
        chk_eq("R10 flag cleared", int'(conv_done), 0);
        step(1);

        // R3: software start with auto triggering on
        cfg_auto_en  = 1'b1;
        cfg_trig_sel = 3'd3;
        step(1);
        exp_q.push_back("R3 auto on");
        pulse_start();
        @(negedge clk);
        chk_eq("R3 busy with auto on", int'(conv_busy), 1);
        wait_empty();

        // R5: edge on selected line (code 3 -> trig_in[2])
        trig_in[2] = 1'b1;
        exp_q.push_back("R5");
        step(1);
        @(negedge clk);
        chk_eq("R5 busy after edge", int'(conv_busy), 1);
        // R6: edge while busy is dropped
        step(1);
        trig_in[2] = 1'b0;
        step(2);
        trig_in[2] = 1'b1;
        step(1);
        wait_empty();
        busy_stays_low("R6 edge during busy dropped", 40);
        trig_in[2] = 1'b0;
        step(1);

        // R5: non-selected line and auto off
        trig_in[0] = 1'b1;
        step(1);
        busy_stays_low("R5 unselected line ignored", 20);
        trig_in[0] = 1'b0;
        cfg_auto_en = 1'b0;
        step(1);
        trig_in[2] = 1'b1;
        step(1);
        busy_stays_low("R5 edge ignored with auto off", 20);
        trig_in[2] = 1'b0;
        step(1);

        // R8: free-running needs a first start
        pulse_clear();
        cfg_auto_en  = 1'b1;
        cfg_trig_sel = 3'd0;
        step(1);
        busy_stays_low("R8 no start without strobe", 60);

        // R7: free-running, flag never cleared
        exp_q.push_back("R7 a");
        exp_q.push_back("R7 b");
        exp_q.push_back("R7 c");
        pulse_start();
        wait_empty();
        cfg_auto_en = 1'b0;
        exp_q.push_back("R7 d");
        @(negedge clk);
        chk_eq("R7 restarted after one idle cycle", int'(conv_busy), 1);
        chk_eq("R7 flag left set", int'(conv_done), 1);
        wait_empty();
        busy_stays_low("R7 stops when auto off", 40);

        // R9: amplified channel blocks self restart
        chan_amplified = 1'b1;
        cfg_auto_en    = 1'b1;
        step(1);
        exp_q.push_back("R9");
        pulse_start();
        wait_empty();
        busy_stays_low("R9 no restart on amplified channel", 60);
        chan_amplified = 1'b0;
        cfg_auto_en    = 1'b0;
        step(1);

        // R2: disabling aborts a conversion
        pulse_start();
        step(5);
        cfg_enable = 1'b0;
        step(1);
        @(negedge clk);
        chk_eq("R2 abort on disable", int'(conv_busy), 0);
        step(2);
        chk_eq("R2 no completions pending", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule